// File: doc/BRIEF.md
# Quad Wiper Register Command Engine

This block runs the byte-level command set for four potentiometer channels. Each channel has a live wiper position register and four stored positions that stand in for nonvolatile memory. A serial front end, which is not part of this block, marks the start and stop of each frame and hands over the received bytes. While the engine is in step mode, the front end also reports each bus clock pulse together with the level of the data line at that pulse. The first byte of a frame is the instruction. Depending on its opcode, the engine moves a value between a channel's live position and one of its stored positions, moves values for all four channels at once, answers a host read, takes a host write from the second byte, or enters step mode to nudge one wiper up or down.

A write into a live position register takes effect at the wiper output only after a fixed number of cycles (`T_WRL`). A write into the stored array holds `busy` high for `T_WR` cycles. While `busy` is high, every new instruction is dropped. Malformed instructions are dropped without touching any state.

Top module: `quad_wiper_engine`

## Requirements
- R1: The instruction byte is decoded as opcode in bits [7:4], stored-slot select in bits [3:2] and channel select in bits [1:0]. An opcode outside the nine listed in R2 to R9 is ignored.
- R2: Opcode 1001 with slot bits 00 places the selected channel's live position, zero-extended to 8 bits, on `rd_data`. `rd_valid` is high for exactly one cycle, the cycle after the instruction byte is accepted.
- R3: Opcode 1011 returns the selected stored slot of the selected channel, using the same timing as R2.
- R4: Opcode 1010 with slot bits 00, followed by a data byte, loads the data byte's low `W` bits into the channel's live position. `wiper_pos` shows the new value exactly `T_WRL` cycles after the data byte is taken.
- R5: Opcode 1100, followed by a data byte, writes the data byte's low `W` bits into the selected stored slot. `busy` then stays high for exactly `T_WR` cycles.
- R6: Opcode 1101 copies the selected stored slot into the channel's live position as soon as the instruction byte is taken. No data byte is needed.
- R7: Opcode 1110 copies the channel's live position into the selected stored slot as soon as the instruction byte is taken, and raises `busy` as in R5.
- R8: Opcode 0001 (stored slot to live position) and opcode 1000 (live position to stored slot) act on all four channels at once through the slot chosen by bits [3:2]. The channel bits must be 00.
- R9: Opcode 0010 with slot bits 00 enters step mode on the selected channel. Each `step_pulse` with `step_level` high adds one to the position and each with `step_level` low subtracts one, saturating at 0 and at 2^W-1. Step mode ends at frame stop.
- R10: An instruction that breaks a zero-field rule (the slot bits in R2, R4 and R9, or the channel bits in R8) is ignored and changes no register.
- R11: An instruction that arrives while `busy` is high is ignored, together with its data byte.
- R12: A frame stop that arrives before a required data byte aborts the command and changes no register.
- R13: After reset, all live and stored positions equal `RST_POS` (default 0) and `busy` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_start | input | 1 | One-cycle strobe: a frame begins |
| frm_stop | input | 1 | One-cycle strobe: the frame ends |
| byte_vld | input | 1 | `byte_data` carries a received byte this cycle |
| byte_data | input | 8 | Received byte |
| step_pulse | input | 1 | One bus clock pulse seen while in step mode |
| step_level | input | 1 | Data line level for that pulse: 1 steps up, 0 steps down |
| rd_valid | output | 1 | `rd_data` carries a read result |
| rd_data | output | 8 | Zero-extended read result |
| busy | output | 1 | Stored-array write in progress |
| wiper_pos | output | 4*W | Delayed live positions, channel c in bits [c*W +: W] |

## Verification
The assertions assume that the front end never raises more than one of `frm_start`, `frm_stop` and `byte_vld` in the same cycle. They also assume that `step_pulse` arrives only between frame strobes. The bench drives every strobe as a single-cycle pulse on the falling clock edge, with at least one idle cycle after it, so these conditions always hold. Commands sent during `busy` are placed deliberately inside the `T_WR` window, which is long enough to contain a whole two-byte frame.

// File: rtl/wpe_pkg.sv
// Shared types for the quad wiper command engine.
// Assumes a fixed 8-bit instruction layout: opcode, slot select, channel select.
package wpe_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        K_NONE, K_RD_WCR, K_WR_WCR, K_RD_DR, K_WR_DR,
        K_DR2WCR, K_WCR2DR, K_G_DR2WCR, K_G_WCR2DR, K_STEP
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e  kind;
        logic [1:0] rsel;
        logic [1:0] psel;
    } cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_INSTR, ST_DATA, ST_STEP, ST_HOLD
    } eng_state_e;
endpackage

// File: rtl/wpe_decode.sv
// Instruction decoder: maps an instruction byte to a command kind and selects.
// Encodings that break a zero-field rule decode to K_NONE, so they are dropped.
// Purely combinational; assumes the byte is stable while it is sampled.
module wpe_decode
    import wpe_pkg::*;
(
    input  logic [7:0] instr,
    output cmd_t       cmd
);
    logic r_zero;
    logic p_zero;

    // Classify the opcode nibble and apply the zero-field rules.
    always_comb begin
        r_zero   = (instr[3:2] == 2'b00);
        p_zero   = (instr[1:0] == 2'b00);
        cmd.rsel = instr[3:2];
        cmd.psel = instr[1:0];
        unique case (instr[7:4])
            4'b1001: cmd.kind = r_zero ? K_RD_WCR : K_NONE;
            4'b1010: cmd.kind = r_zero ? K_WR_WCR : K_NONE;
            4'b1011: cmd.kind = K_RD_DR;
            4'b1100: cmd.kind = K_WR_DR;
            4'b1101: cmd.kind = K_DR2WCR;
            4'b1110: cmd.kind = K_WCR2DR;
            4'b0001: cmd.kind = p_zero ? K_G_DR2WCR : K_NONE;
            4'b1000: cmd.kind = p_zero ? K_G_WCR2DR : K_NONE;
            4'b0010: cmd.kind = r_zero ? K_STEP : K_NONE;
            default: cmd.kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/wpe_nv_store.sv
// Modelled nonvolatile store: CH channels x NREG slots of W bits.
// A write of one slot, or of one slot in every channel, lands at once, and
// busy is held for T_WR cycles. Assumes the control logic never writes while busy.
module wpe_nv_store #(
    parameter int CH    = 4,
    parameter int NREG  = 4,
    parameter int W     = 6,
    parameter int T_WR  = 20,
    parameter logic [W-1:0] RST_POS = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_one,
    input  logic                      we_all,
    input  logic [$clog2(CH)-1:0]     wr_psel,
    input  logic [$clog2(NREG)-1:0]   wr_rsel,
    input  logic [W-1:0]              wr_one_data,
    input  logic [CH*W-1:0]           wr_all_data,
    input  logic [$clog2(CH)-1:0]     rd_psel,
    input  logic [$clog2(NREG)-1:0]   rd_rsel,
    output logic [W-1:0]              rd_one,
    output logic [CH*W-1:0]           rd_all,
    output logic                      busy
);
    localparam int CW = $clog2(T_WR + 1);

    logic [W-1:0]  mem [CH][NREG];
    logic [CW-1:0] cnt;

    // Slot storage: reset to RST_POS, then single or all-channel writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < CH; c++)
                for (int r = 0; r < NREG; r++)
                    mem[c][r] <= RST_POS;
        end else if (we_all) begin
            for (int c = 0; c < CH; c++)
                mem[c][wr_rsel] <= wr_all_data[c*W +: W];
        end else if (we_one) begin
            mem[wr_psel][wr_rsel] <= wr_one_data;
        end
    end

    // Write-time model: counts T_WR cycles down after each write.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (we_one || we_all) cnt <= CW'(T_WR);
        else if (cnt != '0)        cnt <= cnt - 1'b1;
    end

    assign busy   = (cnt != '0);
    assign rd_one = mem[rd_psel][rd_rsel];

    for (genvar c = 0; c < CH; c++) begin : g_rd
        assign rd_all[c*W +: W] = mem[c][rd_rsel];
    end

    a_r11_no_write_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (we_one || we_all) |-> !busy);
    a_r5_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we_one || we_all) |=> busy);
    a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(T_WR));
endmodule

// File: rtl/wpe_wiper_chan.sv
// One channel's live position register with saturating step, and a T_WRL-stage
// delay line that drives the visible wiper position. A load wins over a step.
// Assumes T_WRL >= 1.
module wpe_wiper_chan #(
    parameter int W     = 6,
    parameter int T_WRL = 3,
    parameter logic [W-1:0] RST_POS = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step_en,
    input  logic         step_up,
    output logic [W-1:0] wcr,
    output logic [W-1:0] wiper_out
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] dly [T_WRL];

    // Live position: load, or a saturating single-step move.
    always_ff @(posedge clk) begin
        if (!rst_n)                          wcr <= RST_POS;
        else if (load)                       wcr <= load_val;
        else if (step_en && step_up && wcr != TOP)  wcr <= wcr + 1'b1;
        else if (step_en && !step_up && wcr != '0)  wcr <= wcr - 1'b1;
    end

    // Volatile update delay: shift the live value through T_WRL stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < T_WRL; i++) dly[i] <= RST_POS;
        end else begin
            dly[0] <= wcr;
            for (int i = 1; i < T_WRL; i++) dly[i] <= dly[i-1];
        end
    end

    assign wiper_out = dly[T_WRL-1];

    a_r9_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && step_up && !load && wcr == TOP) |=> wcr == TOP);
    a_r9_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !step_up && !load && wcr == '0) |=> wcr == '0);
    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step_en) |=> $stable(wcr));
endmodule

// File: rtl/quad_wiper_engine.sv
// Command engine for four wiper channels. Takes frame strobes and bytes from a
// serial front end, decodes the instruction, and runs reads, writes, single and
// global transfers, and step mode. Assumes the front end raises at most one of
// frm_start, frm_stop and byte_vld per cycle, and step_pulse only inside a frame.
module quad_wiper_engine
    import wpe_pkg::*;
#(
    parameter int W     = 6,
    parameter int T_WRL = 3,
    parameter int T_WR  = 20,
    parameter logic [W-1:0] RST_POS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_start,
    input  logic              frm_stop,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              step_pulse,
    input  logic              step_level,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic [4*W-1:0]    wiper_pos
);
    localparam int CH   = 4;
    localparam int NREG = 4;

    eng_state_e   st;
    cmd_t         dec;
    cmd_t         pend;
    logic         no_strobe, instr_take, data_take, accept;
    logic         we_one, we_all;
    logic [1:0]   wr_psel, wr_rsel;
    logic [W-1:0] wr_one_data, nv_rd_one;
    logic [CH*W-1:0] wr_all_data, nv_rd_all;
    logic [CH-1:0]   ch_load, ch_step;
    logic [W-1:0]    ch_val [CH];
    logic [W-1:0]    wcr_v  [CH];

    wpe_decode u_dec (.instr(byte_data), .cmd(dec));

    assign no_strobe  = !frm_start && !frm_stop;
    assign instr_take = (st == ST_INSTR) && byte_vld && no_strobe;
    assign data_take  = (st == ST_DATA)  && byte_vld && no_strobe;
    assign accept     = instr_take && !busy && (dec.kind != K_NONE);

    // Action fan-out: turn the accepted command into load, step and store strobes.
    always_comb begin
        we_one      = 1'b0;
        we_all      = 1'b0;
        wr_psel     = dec.psel;
        wr_rsel     = dec.rsel;
        wr_one_data = '0;
        ch_load     = '0;
        ch_step     = '0;
        for (int c = 0; c < CH; c++) ch_val[c] = nv_rd_all[c*W +: W];
        if (accept) begin
            unique case (dec.kind)
                K_DR2WCR: begin
                    ch_load[dec.psel] = 1'b1;
                    ch_val[dec.psel]  = nv_rd_one;
                end
                K_WCR2DR: begin
                    we_one      = 1'b1;
                    wr_one_data = wcr_v[dec.psel];
                end
                K_G_DR2WCR: ch_load = '1;
                K_G_WCR2DR: we_all  = 1'b1;
                default: ;
            endcase
        end
        if (data_take) begin
            wr_psel = pend.psel;
            wr_rsel = pend.rsel;
            if (pend.kind == K_WR_WCR) begin
                ch_load[pend.psel] = 1'b1;
                ch_val[pend.psel]  = byte_data[W-1:0];
            end else if (pend.kind == K_WR_DR) begin
                we_one      = 1'b1;
                wr_one_data = byte_data[W-1:0];
            end
        end
        if (st == ST_STEP && step_pulse && no_strobe)
            ch_step[pend.psel] = 1'b1;
    end

    // Frame sequencer: instruction, optional data byte, step mode, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            pend <= '{kind: K_NONE, rsel: 2'b00, psel: 2'b00};
        end else if (frm_start) begin
            st <= ST_INSTR;
        end else if (frm_stop) begin
            st <= ST_IDLE;
        end else if (instr_take) begin
            pend <= dec;
            if (accept && (dec.kind == K_WR_WCR || dec.kind == K_WR_DR))
                st <= ST_DATA;
            else if (accept && dec.kind == K_STEP)
                st <= ST_STEP;
            else
                st <= ST_HOLD;
        end else if (data_take) begin
            st <= ST_HOLD;
        end
    end

    // Read port: register the selected value one cycle after the instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= accept && (dec.kind == K_RD_WCR || dec.kind == K_RD_DR);
            if (accept && dec.kind == K_RD_WCR)
                rd_data <= BYTE_W'(wcr_v[dec.psel]);
            else if (accept && dec.kind == K_RD_DR)
                rd_data <= BYTE_W'(nv_rd_one);
        end
    end

    for (genvar c = 0; c < CH; c++) begin : g_ch
        assign wr_all_data[c*W +: W] = wcr_v[c];
        wpe_wiper_chan #(.W(W), .T_WRL(T_WRL), .RST_POS(RST_POS)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ch_load[c]),
            .load_val (ch_val[c]),
            .step_en  (ch_step[c]),
            .step_up  (step_level),
            .wcr      (wcr_v[c]),
            .wiper_out(wiper_pos[c*W +: W])
        );
    end

    wpe_nv_store #(.CH(CH), .NREG(NREG), .W(W), .T_WR(T_WR), .RST_POS(RST_POS)) u_nv (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_one     (we_one),
        .we_all     (we_all),
        .wr_psel    (wr_psel),
        .wr_rsel    (wr_rsel),
        .wr_one_data(wr_one_data),
        .wr_all_data(wr_all_data),
        .rd_psel    (dec.psel),
        .rd_rsel    (dec.rsel),
        .rd_one     (nv_rd_one),
        .rd_all     (nv_rd_all),
        .busy       (busy)
    );

    a_r2_read_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    a_r11_busy_drops_read: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_take && busy) |=> !rd_valid);
    a_r12_abort_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && frm_stop && !busy) |=> !busy);
    a_r10_rejected_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_take && dec.kind == K_NONE) |=> !rd_valid);
endmodule

// File: tb/tb_quad_wiper_engine.sv
`timescale 1ns/1ps
module tb_quad_wiper_engine;
    localparam int W     = 6;
    localparam int T_WRL = 3;
    localparam int T_WR  = 20;
    localparam int NV    = 14;

    // Fields: cmd, data, has data byte, read-back cmd, expected value, requirement.
    localparam logic [34:0] VEC [NV] = '{
        {8'hA1, 8'h15, 1'b1, 8'h91, 6'h15, 4'd4},  // R4 write live p1; R1 layout; R2 read
        {8'hCE, 8'h2A, 1'b1, 8'hBE, 6'h2A, 4'd5},  // R5 store p2 slot3; R3 read
        {8'hDE, 8'h00, 1'b0, 8'h92, 6'h2A, 4'd6},  // R6 slot3 -> live p2
        {8'hE1, 8'h00, 1'b0, 8'hB1, 6'h15, 4'd7},  // R7 live p1 -> slot0
        {8'hA3, 8'h3F, 1'b1, 8'h93, 6'h3F, 4'd4},  // R4 write live p3
        {8'h88, 8'h00, 1'b0, 8'hBB, 6'h3F, 4'd8},  // R8 global live -> slot2
        {8'h00, 8'h00, 1'b0, 8'hB9, 6'h15, 4'd8},  // R8 p1 slot2
        {8'hC4, 8'h07, 1'b1, 8'hB4, 6'h07, 4'd5},  // R5 store p0 slot1
        {8'h14, 8'h00, 1'b0, 8'h90, 6'h07, 4'd8},  // R8 global slot1 -> live
        {8'h00, 8'h00, 1'b0, 8'h91, 6'h00, 4'd8},  // R8 p1 took slot1
        {8'h30, 8'h00, 1'b0, 8'h90, 6'h07, 4'd10}, // R10 unlisted opcode
        {8'hA4, 8'h11, 1'b1, 8'h90, 6'h07, 4'd10}, // R10 slot bits set on live write
        {8'h1B, 8'h00, 1'b0, 8'h90, 6'h07, 4'd10}, // R10 channel bits set on global
        {8'hA0, 8'h00, 1'b0, 8'h90, 6'h07, 4'd12}  // R12 stop before data byte
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic frm_start = 0, frm_stop = 0, byte_vld = 0, step_pulse = 0, step_level = 0;
    logic [7:0] byte_data = '0;
    logic rd_valid, busy;
    logic [7:0] rd_data;
    logic [4*W-1:0] wiper_pos;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    quad_wiper_engine #(.W(W), .T_WRL(T_WRL), .T_WR(T_WR)) dut (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_stop(frm_stop),
        .byte_vld(byte_vld), .byte_data(byte_data), .step_pulse(step_pulse),
        .step_level(step_level), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .wiper_pos(wiper_pos)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_frame();
        @(negedge clk) frm_start = 1;
        @(negedge clk) frm_start = 0;
    endtask
    task automatic stop_frame();
        @(negedge clk) frm_stop = 1;
        @(negedge clk) frm_stop = 0;
    endtask
    task automatic put_byte(input logic [7:0] b);
        @(negedge clk) begin byte_vld = 1; byte_data = b; end
        @(negedge clk) byte_vld = 0;
    endtask
    task automatic pulse(input logic lvl);
        @(negedge clk) begin step_pulse = 1; step_level = lvl; end
        @(negedge clk) step_pulse = 0;
    endtask
    task automatic cmd2(input logic [7:0] c, input logic [7:0] d);
        start_frame(); put_byte(c); put_byte(d); stop_frame();
    endtask
    task automatic settle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (T_WRL + 2) @(negedge clk);
    endtask
    task automatic do_read(input logic [7:0] c, output logic [7:0] v, output logic vld);
        start_frame(); put_byte(c);
        vld = rd_valid; v = rd_data;
        stop_frame();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic vld;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R13: reset state
        chk("R13 busy", 32'(busy), 0);
        chk("R13 rd_valid", 32'(rd_valid), 0);
        chk("R13 wiper_pos", 32'(wiper_pos), 0);

        for (int i = 0; i < NV; i++) begin
            start_frame();
            put_byte(VEC[i][34:27]);
            if (VEC[i][18]) put_byte(VEC[i][26:19]);
            stop_frame();
            settle();
            do_read(VEC[i][17:10], v, vld);
            chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), 32'(v), 32'(VEC[i][9:4]));
        end

        // R2: read valid is a one-cycle pulse
        start_frame(); put_byte(8'h90);
        chk("R2 valid high", 32'(rd_valid), 1);
        @(negedge clk);
        chk("R2 valid single", 32'(rd_valid), 0);
        stop_frame();

        // R4: wiper output latency of T_WRL cycles
        start_frame(); put_byte(8'hA2); put_byte(8'h0A);
        repeat (T_WRL - 1) @(negedge clk);
        chk("R4 before latency", 32'(wiper_pos[2*W +: W]), 0);
        @(negedge clk);
        chk("R4 at latency", 32'(wiper_pos[2*W +: W]), 32'h0A);
        stop_frame(); settle();

        // R5: busy lasts exactly T_WR cycles
        start_frame(); put_byte(8'hC0); put_byte(8'h05);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        chk("R5 busy length", 32'(n), 32'(T_WR));
        stop_frame(); settle();

        // R11: a command sent during busy is dropped
        cmd2(8'hC1, 8'h09);
        chk("R11 busy during test", 32'(busy), 1);
        cmd2(8'hA0, 8'h33);
        settle();
        do_read(8'h90, v, vld);
        chk("R11 live p0 kept", 32'(v), 32'h07);
        do_read(8'hB1, v, vld);
        chk("R11 first store landed", 32'(v), 32'h09);

        // R9: step up saturates at the top, down moves by one, stop ends mode
        cmd2(8'hA0, 8'h3D);
        start_frame(); put_byte(8'h20);
        repeat (5) pulse(1'b1);
        repeat (2) pulse(1'b0);
        stop_frame();
        repeat (2) pulse(1'b1);
        settle();
        do_read(8'h90, v, vld);
        chk("R9 saturate high then down", 32'(v), 32'h3D);
        cmd2(8'hA0, 8'h01);
        start_frame(); put_byte(8'h20);
        repeat (3) pulse(1'b0);
        stop_frame(); settle();
        do_read(8'h90, v, vld);
        chk("R9 saturate low", 32'(v), 0);
        chk("R9 wiper output low", 32'(wiper_pos[0 +: W]), 0);
        do_read(8'h91, v, vld);
        chk("R9 other channel untouched", 32'(v), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule